// File: doc/BRIEF.md
# Vector Sign-Transfer Unit

This block applies the sign of one vector to the magnitude of another, lane by lane. A 512-bit vector is split into 16-bit or 32-bit lanes. In each lane the output is operand b, or b negated when the top bit of the matching lane of operand a is set. No product is formed. Only the sign bit of a matters, so the unit costs one negate and one select per lane instead of a multiplier array.

Software uses it to restore a sign that was stored apart from a magnitude. A mode input picks wrapping or clamping for the single case that overflows: negating the most negative lane value. Each operation is presented with `in_valid` together with its lane width and overflow mode. The result appears registered on the next cycle with `out_valid`. A two-flop synchronizer releases the asynchronous reset inside the block. The output register therefore stays cleared for two clock edges after `rst_n` rises.

Top module: `sgnx_unit`

## Requirements
- R1: While reset is held, and for the two rising edges after `rst_n` rises, `out_valid` is 0 and `out_data` is all zeros.
- R2: `out_valid` is 1 in exactly the cycles that follow a rising edge at which `in_valid` was 1. Each accepted operation produces exactly one result, in order.
- R3: With `in_wide`=0, lane i is bits [16i+15:16i]. When bit 16i+15 of `in_a` is 1, the lane output is the two's-complement negation of the b lane, modulo 2^16.
- R4: The magnitude of an a lane is ignored and only its top bit is tested. An a lane of zero, or any a lane with a clear top bit, passes the b lane through unchanged.
- R5: With `in_wide`=1, lane i is bits [32i+31:32i]. The lane output is the b lane when bit 32i+31 of `in_a` is 0, and its negation modulo 2^32 otherwise. There is no widening, and a 32-bit lane is never split into halves.
- R6: With `in_sat`=0, negating 16'h8000 yields 16'h8000 and negating 32'h80000000 yields 32'h80000000.
- R7: With `in_sat`=1, negating 16'h8000 yields 16'h7FFF and negating 32'h80000000 yields 32'h7FFFFFFF. All other lane values follow R3 and R5.
- R8: In a cycle that follows a rising edge with `in_valid`=0, `out_data` keeps its previous value.
- R9: Lane width and overflow mode are taken from the same edge as the operands. Back-to-back operations with different modes each get their own mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation present on the inputs this cycle |
| in_wide | input | 1 | 0: 16-bit lanes, 1: 32-bit lanes |
| in_sat | input | 1 | 0: wrap on minimum negation, 1: clamp to maximum |
| in_a | input | 512 | Sign source vector |
| in_b | input | 512 | Magnitude vector |
| out_valid | output | 1 | Result present on `out_data` |
| out_data | output | 512 | Registered sign-transferred vector |

## Verification
The properties assume that `in_valid`, `in_wide`, `in_sat` and both operand vectors are at known levels at every sampled edge once the internal reset has released. They also assume that the lane-0 slices of `in_a` and `in_b` stand for every lane, since the lanes are identical copies. The bench drives every input from a defined value before reset is released. It holds `in_valid` low until well after the internal two-edge release, and it changes inputs only on falling edges. Corner operands are placed in all lanes at once, including 0x8000 and 0x80000000 magnitudes and zero or sign-only a lanes. As a result, the lane-0 properties see the same cases that the scoreboard checks across the full width.

// File: rtl/sgnx_pkg.sv
package sgnx_pkg;
  localparam int NARROW_W = 16;
  localparam int WIDE_W   = 32;

  typedef struct packed {
    logic wide;
    logic sat;
  } sgnx_mode_t;
endpackage

// File: rtl/sgnx_rst_sync.sv
module sgnx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_nxt;

  always_comb begin
    sync_nxt = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_nxt;
    end
  end

  assign rst_core_n = sync_q[STAGES-1];
endmodule

// File: rtl/sgnx_lane.sv
module sgnx_lane #(
  parameter int LANE_W = 16
) (
  input  logic              neg_sel,
  input  logic              sat_en,
  input  logic [LANE_W-1:0] mag,
  output logic [LANE_W-1:0] res
);
  localparam logic [LANE_W-1:0] MIN_V = {1'b1, {(LANE_W-1){1'b0}}};
  localparam logic [LANE_W-1:0] MAX_V = ~MIN_V;
  localparam logic [LANE_W-1:0] ONE_V = {{(LANE_W-1){1'b0}}, 1'b1};

  logic [LANE_W-1:0] negated;
  logic              at_min;

  always_comb begin
    negated = (~mag) + ONE_V;
    at_min  = (mag == MIN_V);
    if (!neg_sel) begin
      res = mag;
    end else if (sat_en && at_min) begin
      res = MAX_V;
    end else begin
      res = negated;
    end
  end
endmodule

// File: rtl/sgnx_lane_array.sv
module sgnx_lane_array #(
  parameter int VEC_W  = 512,
  parameter int LANE_W = 16
) (
  input  logic [VEC_W-1:0] a_vec,
  input  logic [VEC_W-1:0] b_vec,
  input  logic             sat_en,
  output logic [VEC_W-1:0] y_vec
);
  localparam int N_LANES = VEC_W / LANE_W;

  logic unused_a_bits;
  assign unused_a_bits = ^a_vec;

  for (genvar gi = 0; gi < N_LANES; gi++) begin : g_lane
    sgnx_lane #(.LANE_W(LANE_W)) u_lane (
      .neg_sel (a_vec[gi*LANE_W + LANE_W - 1]),
      .sat_en  (sat_en),
      .mag     (b_vec[gi*LANE_W +: LANE_W]),
      .res     (y_vec[gi*LANE_W +: LANE_W])
    );
  end
endmodule

// File: rtl/sgnx_out_stage.sv
module sgnx_out_stage #(
  parameter int DATA_W = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] d,
  output logic              q_valid,
  output logic [DATA_W-1:0] q
);
  logic              valid_q;
  logic              valid_nxt;
  logic [DATA_W-1:0] data_q;
  logic [DATA_W-1:0] data_nxt;

  always_comb begin
    valid_nxt = load;
    data_nxt  = load ? d : data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= valid_nxt;
      data_q  <= data_nxt;
    end
  end

  assign q_valid = valid_q;
  assign q       = data_q;
endmodule

// File: rtl/sgnx_unit.sv
module sgnx_unit
  import sgnx_pkg::*;
#(
  parameter int VEC_W = 512
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_wide,
  input  logic             in_sat,
  input  logic [VEC_W-1:0] in_a,
  input  logic [VEC_W-1:0] in_b,
  output logic             out_valid,
  output logic [VEC_W-1:0] out_data
);
  localparam int N_NARROW = VEC_W / NARROW_W;
  localparam int N_WIDE   = VEC_W / WIDE_W;

  logic             rst_core_n;
  sgnx_mode_t       mode;
  logic [VEC_W-1:0] res_narrow;
  logic [VEC_W-1:0] res_wide;
  logic [VEC_W-1:0] res_sel;

  sgnx_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_core_n (rst_core_n)
  );

  assign mode = '{wide: in_wide, sat: in_sat};

  sgnx_lane_array #(.VEC_W(N_NARROW * NARROW_W), .LANE_W(NARROW_W)) u_narrow (
    .a_vec  (in_a),
    .b_vec  (in_b),
    .sat_en (mode.sat),
    .y_vec  (res_narrow)
  );

  sgnx_lane_array #(.VEC_W(N_WIDE * WIDE_W), .LANE_W(WIDE_W)) u_wide (
    .a_vec  (in_a),
    .b_vec  (in_b),
    .sat_en (mode.sat),
    .y_vec  (res_wide)
  );

  always_comb begin
    res_sel = mode.wide ? res_wide : res_narrow;
  end

  sgnx_out_stage #(.DATA_W(VEC_W)) u_out (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .load    (in_valid),
    .d       (res_sel),
    .q_valid (out_valid),
    .q       (out_data)
  );
endmodule

// File: rtl/sgnx_unit_chk.sv
module sgnx_unit_chk #(
  parameter int VEC_W = 512
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_wide,
  input logic             in_sat,
  input logic             a_msb16,
  input logic             a_msb32,
  input logic [31:0]      b_lo,
  input logic [31:0]      out_lo,
  input logic             out_valid,
  input logic [VEC_W-1:0] out_data
);
  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_valid_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  assert_hold_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_data));

  assert_negate16_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_wide && a_msb16 && b_lo[15:0] != 16'h8000)
      |=> (16'(out_lo[15:0] + $past(b_lo[15:0])) == 16'h0000));

  assert_pass16_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_wide && !a_msb16) |=> (out_lo[15:0] == $past(b_lo[15:0])));

  assert_pass32_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_wide && !a_msb32) |=> (out_lo == $past(b_lo)));

  assert_wrap16_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_wide && !in_sat && a_msb16 && b_lo[15:0] == 16'h8000)
      |=> (out_lo[15:0] == 16'h8000));

  assert_sat16_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_wide && in_sat && a_msb16 && b_lo[15:0] == 16'h8000)
      |=> (out_lo[15:0] == 16'h7FFF));

  assert_sat32_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_wide && in_sat && a_msb32 && b_lo == 32'h8000_0000)
      |=> (out_lo == 32'h7FFF_FFFF));
endmodule

bind sgnx_unit sgnx_unit_chk #(.VEC_W(VEC_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_core_n),
  .in_valid  (in_valid),
  .in_wide   (in_wide),
  .in_sat    (in_sat),
  .a_msb16   (in_a[15]),
  .a_msb32   (in_a[31]),
  .b_lo      (in_b[31:0]),
  .out_lo    (out_data[31:0]),
  .out_valid (out_valid),
  .out_data  (out_data)
);

// File: tb/sim_sgnx_unit.sv
`timescale 1ns/1ps
module sim_sgnx_unit;
  localparam int VW = 512;

  typedef struct {
    logic [VW-1:0] exp;
    string         tag;
  } sb_item_t;

  logic          clk;
  logic          rst_n;
  logic          in_valid;
  logic          in_wide;
  logic          in_sat;
  logic [VW-1:0] in_a;
  logic [VW-1:0] in_b;
  logic          out_valid;
  logic [VW-1:0] out_data;

  int checks;
  int errors;
  bit mon_en;
  bit have_last;
  logic [VW-1:0] last_exp;
  sb_item_t sb[$];

  sgnx_unit #(.VEC_W(VW)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_wide(in_wide),
    .in_sat(in_sat), .in_a(in_a), .in_b(in_b),
    .out_valid(out_valid), .out_data(out_data)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [VW-1:0] model(input logic [VW-1:0] a, input logic [VW-1:0] b,
                                          input logic wide, input logic sat);
    logic [VW-1:0] r;
    logic [15:0]   h;
    logic [31:0]   w;
    r = '0;
    if (!wide) begin
      for (int l = 0; l < VW/16; l++) begin
        h = b[l*16 +: 16];
        if (a[l*16+15]) h = (sat && h == 16'h8000) ? 16'h7FFF : 16'(-h);
        r[l*16 +: 16] = h;
      end
    end else begin
      for (int l = 0; l < VW/32; l++) begin
        w = b[l*32 +: 32];
        if (a[l*32+31]) w = (sat && w == 32'h8000_0000) ? 32'h7FFF_FFFF : 32'(-w);
        r[l*32 +: 32] = w;
      end
    end
    return r;
  endfunction

  function automatic logic [VW-1:0] rand_vec();
    logic [VW-1:0] v;
    for (int k = 0; k < VW/32; k++) v[k*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic send(input logic [VW-1:0] a, input logic [VW-1:0] b,
                      input logic wide, input logic sat, input string tag);
    sb_item_t it;
    @(negedge clk);
    in_a = a; in_b = b; in_wide = wide; in_sat = sat; in_valid = 1'b1;
    it.exp = model(a, b, wide, sat);
    it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  // Monitor: pops expected results as the design produces them
  always @(negedge clk) begin
    if (mon_en) begin
      if (out_valid) begin
        checks++;
        if (sb.size() == 0) begin
          errors++;
          $display("FAIL R2 unexpected out_valid actual=1 expected=0");
        end else begin
          sb_item_t it;
          it = sb.pop_front();
          if (out_data !== it.exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", it.tag, out_data, it.exp);
          end
          last_exp  = it.exp;
          have_last = 1'b1;
        end
      end else if (have_last) begin
        checks++;
        if (out_data !== last_exp) begin
          errors++;
          $display("FAIL R8 idle hold actual=%h expected=%h", out_data, last_exp);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    logic [VW-1:0] a;
    logic [VW-1:0] b;
    checks = 0; errors = 0; mon_en = 0; have_last = 0; last_exp = '0;
    in_valid = 0; in_wide = 0; in_sat = 0; in_a = '0; in_b = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_data !== '0) begin
      errors++;
      $display("FAIL R1 reset state actual=%b/%h expected=0/0", out_valid, out_data);
    end
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_data !== '0) begin
      errors++;
      $display("FAIL R1 during release actual=%b/%h expected=0/0", out_valid, out_data);
    end
    repeat (4) @(negedge clk);
    mon_en = 1'b1;

    // R3: all a negative, random b, 16-bit lanes
    send({32{16'hF123}}, rand_vec(), 1'b0, 1'b0, "R3 negate16");
    // R4: a positive, random b
    send({32{16'h7FFF}}, rand_vec(), 1'b0, 1'b0, "R4 pass16");
    // R4: a mixes zero, small, sign-only and all-ones lanes
    send({8{16'hFFFF, 16'h8000, 16'h0001, 16'h0000}}, rand_vec(), 1'b0, 1'b1, "R4 mixed a");
    idle(3);
    // R6 / R7: minimum magnitude in 16-bit lanes
    send({32{16'h8000}}, {32{16'h8000}}, 1'b0, 1'b0, "R6 wrap16");
    send({32{16'h8000}}, {32{16'h8000}}, 1'b0, 1'b1, "R7 sat16");
    send({32{16'hFFFF}}, {16{16'h8000, 16'h8001}}, 1'b0, 1'b1, "R7 sat16 neighbour");
    // R5: 32-bit lanes
    send({16{32'h8000_0000}}, rand_vec(), 1'b1, 1'b0, "R5 negate32");
    send({16{32'h7FFF_8000}}, rand_vec(), 1'b1, 1'b0, "R5 pass32 low half sign");
    send({16{32'h8000_0000}}, {16{32'h8000_0000}}, 1'b1, 1'b0, "R6 wrap32");
    send({16{32'hFFFF_FFFF}}, {16{32'h8000_0000}}, 1'b1, 1'b1, "R7 sat32");
    idle(2);
    // R9: same operands, alternating width and mode back to back
    a = {16{32'h0000_8000}};
    b = {16{32'h0001_8000}};
    send(a, b, 1'b0, 1'b1, "R9 narrow sat");
    send(a, b, 1'b1, 1'b0, "R9 wide wrap");
    send(a, b, 1'b0, 1'b0, "R9 narrow wrap");
    send(a, b, 1'b1, 1'b1, "R9 wide sat");
    idle(2);
    // Random mix with idle gaps
    for (int n = 0; n < 200; n++) begin
      send(rand_vec(), rand_vec(), 1'($urandom), 1'($urandom), "R3 R5 random");
      if (($urandom % 4) == 0) idle(1 + ($urandom % 3));
    end
    idle(4);
    checks++;
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL R2 results missing actual=%0d expected=0", sb.size());
    end
    summary();
    $finish;
  end
endmodule